// File: doc/BRIEF.md
# Token-Gated Channel Readout Sequencer

This block moves the converted counter values of a multi-channel sampler onto a 12-bit data bus that several chips or channel groups share. Ownership of the bus passes along a daisy chain as a single token. A token arrives on `tok_in` while the block is idle. If `ch_addr` names one of the block's local channels, the block takes the token. It then streams that channel's 256 stored words, one per read-clock cycle, in rising index order. After the last word it sends the token on through `tok_out`. If the address names no local channel, the token goes straight through to `tok_out` on the next cycle.

The counter storage sits outside the block, behind a read port. The block presents a channel number and a word index on `rd_ch`/`rd_idx`, and the storage returns the word on `rd_data` within the same cycle. The shared bus is modelled as a data output plus an output enable. While the enable is low, the data output is held at 0, which stands for the weak pull to ground on a released bus. A synchronous clear input returns the token logic to idle from any state.

Top module: `rs_readout_seq`

## Requirements
- R1: While `rst_n` is low, `bus_oe`, `data_valid` and `tok_out` are 0 and `bus_data` is 0.
- R2: A token taken while idle, with `ch_addr` inside [CH_BASE, CH_BASE+N_CH), raises `bus_oe` and `data_valid` from the next cycle for exactly WORDS (256) consecutive cycles.
- R3: In the k-th enabled cycle of a burst (k = 0..255), `rd_idx` equals k and `bus_data` equals the storage word k of channel `ch_addr - CH_BASE`.
- R4: `tok_out` is high for exactly one cycle, namely the cycle right after the last word, and `bus_oe` is low in that cycle.
- R5: A token taken while idle with `ch_addr` outside the local range makes `tok_out` high in the next cycle only, and the bus stays disabled.
- R6: Whenever `bus_oe` is low, `bus_data` is 0.
- R7: `tok_clr` high at a clock edge leaves `bus_oe` and `tok_out` low after that edge. It abandons a running burst without passing the token, and it wins over a `tok_in` sampled at the same edge.
- R8: A token pulse that arrives during a burst is ignored: the burst neither restarts nor lengthens, and no second burst follows it.
- R9: The channel is latched when the token is taken, so a change of `ch_addr` during a burst does not change `rd_ch` or the words driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_in | input | 1 | Token arriving from the previous link of the chain |
| tok_clr | input | 1 | Synchronous clear of the token logic |
| ch_addr | input | AW (5) | Channel address sampled when the token is taken |
| rd_ch | output | CHW (2) | Local channel number presented to the storage |
| rd_idx | output | IW (8) | Word index presented to the storage |
| rd_data | input | DW (12) | Word returned by the storage in the same cycle |
| bus_data | output | DW (12) | Bus data, 0 while released |
| bus_oe | output | 1 | Bus output enable |
| data_valid | output | 1 | Strobe marking each driven word |
| tok_out | output | 1 | Token passed to the next link |

## Verification
The assertions assume that `tok_in`, `tok_clr` and `ch_addr` are synchronous to the read clock and settle well before each rising edge. They also assume that the storage port is a pure function of `rd_ch` and `rd_idx`, answering in the same cycle. The bench drives every input on the falling edge. Its storage model is a fixed arithmetic function of channel and index, so the words it expects come straight from the address and cycle count. Tokens are always single-cycle pulses, so no stimulus relies on behaviour under a held-high `tok_in`.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // True when an address falls inside the local channel window.
  function automatic logic addr_in_window(int unsigned addr, int unsigned base, int unsigned cnt);
    return (addr >= base) && (addr < base + cnt);
  endfunction

  // Offset of an address within the local window.
  function automatic int unsigned addr_offset(int unsigned addr, int unsigned base);
    return addr - base;
  endfunction

  // Index of the final word of a burst.
  function automatic int unsigned last_word(int unsigned words);
    return words - 1;
  endfunction

endpackage

// File: rtl/rs_addr_decode.sv
module rs_addr_decode #(
  parameter int AW      = 5,
  parameter int N_CH    = 4,
  parameter int CH_BASE = 0,
  parameter int CHW     = 2
) (
  input  logic [AW-1:0]  addr,
  output logic           hit,
  output logic [CHW-1:0] local_ch
);
  always_comb begin
    hit      = rs_pkg::addr_in_window(int'(addr), CH_BASE, N_CH);
    local_ch = CHW'(rs_pkg::addr_offset(int'(addr), CH_BASE));
  end
endmodule

// File: rtl/rs_word_counter.sv
module rs_word_counter #(
  parameter int WORDS = 256,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic          run,
  output logic [IW-1:0] idx,
  output logic          last
);
  localparam logic [IW-1:0] LAST_IDX = IW'(rs_pkg::last_word(WORDS));

  assign last = run && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (clr || start || last) begin
      idx <= '0;
    end else if (run) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/rs_token_ctrl.sv
module rs_token_ctrl #(
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tok_clr,
  input  logic           tok_in,
  input  logic           hit,
  input  logic [CHW-1:0] hit_ch,
  input  logic           last,
  output logic           busy,
  output logic [CHW-1:0] cur_ch,
  output logic           tok_out,
  output logic           capture_ev,
  output logic           forward_ev
);
  assign capture_ev = !busy && tok_in &&  hit && !tok_clr;
  assign forward_ev = !busy && tok_in && !hit && !tok_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_ch  <= '0;
      tok_out <= 1'b0;
    end else if (tok_clr) begin
      busy    <= 1'b0;
      tok_out <= 1'b0;
    end else begin
      tok_out <= forward_ev || last;
      if (capture_ev) begin
        busy   <= 1'b1;
        cur_ch <= hit_ch;
      end else if (last) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_bus_drive.sv
module rs_bus_drive #(
  parameter int DW = 12
) (
  input  logic          oe,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] bus_data,
  output logic          bus_oe,
  output logic          data_valid
);
  always_comb begin
    bus_oe     = oe;
    data_valid = oe;
    bus_data   = oe ? word : '0;
  end
endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq #(
  parameter int DW      = 12,
  parameter int AW      = 5,
  parameter int N_CH    = 4,
  parameter int CH_BASE = 0,
  parameter int WORDS   = 256,
  localparam int CHW    = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int IW     = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tok_in,
  input  logic           tok_clr,
  input  logic [AW-1:0]  ch_addr,
  output logic [CHW-1:0] rd_ch,
  output logic [IW-1:0]  rd_idx,
  input  logic [DW-1:0]  rd_data,
  output logic [DW-1:0]  bus_data,
  output logic           bus_oe,
  output logic           data_valid,
  output logic           tok_out
);
  logic           hit;
  logic [CHW-1:0] hit_ch;
  logic           busy;
  logic [CHW-1:0] cur_ch;
  logic [IW-1:0]  idx;
  logic           burst_last;
  logic           capture_ev;
  logic           forward_ev;

  rs_addr_decode #(.AW(AW), .N_CH(N_CH), .CH_BASE(CH_BASE), .CHW(CHW)) dec_i (
    .addr(ch_addr), .hit(hit), .local_ch(hit_ch)
  );

  rs_token_ctrl #(.CHW(CHW)) tok_i (
    .clk(clk), .rst_n(rst_n), .tok_clr(tok_clr), .tok_in(tok_in),
    .hit(hit), .hit_ch(hit_ch), .last(burst_last),
    .busy(busy), .cur_ch(cur_ch), .tok_out(tok_out),
    .capture_ev(capture_ev), .forward_ev(forward_ev)
  );

  rs_word_counter #(.WORDS(WORDS), .IW(IW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(tok_clr), .start(capture_ev),
    .run(busy), .idx(idx), .last(burst_last)
  );

  rs_bus_drive #(.DW(DW)) drv_i (
    .oe(busy), .word(rd_data),
    .bus_data(bus_data), .bus_oe(bus_oe), .data_valid(data_valid)
  );

  assign rd_ch  = cur_ch;
  assign rd_idx = idx;
endmodule

// File: rtl/rs_readout_seq_chk.sv
module rs_readout_seq_chk #(
  parameter int DW  = 12,
  parameter int CHW = 2,
  parameter int IW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tok_in,
  input logic           tok_clr,
  input logic           bus_oe,
  input logic           data_valid,
  input logic [DW-1:0]  bus_data,
  input logic           tok_out,
  input logic [IW-1:0]  rd_idx,
  input logic [CHW-1:0] rd_ch,
  input logic           capture_ev,
  input logic           forward_ev,
  input logic           burst_last
);
  p_released_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0));

  p_capture_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |=> (bus_oe && data_valid && rd_idx == '0));

  p_index_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !burst_last && !tok_clr) |=> (rd_idx == IW'($past(rd_idx) + 1'b1)));

  p_last_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_last && !tok_clr) |=> (tok_out && !bus_oe));

  p_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
    forward_ev |=> (tok_out && !bus_oe));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_clr |=> (!bus_oe && !tok_out));

  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && tok_in && !burst_last && !tok_clr) |=> (bus_oe && rd_idx != '0));

  p_channel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(rd_ch));
endmodule

bind rs_readout_seq rs_readout_seq_chk #(.DW(DW), .CHW(CHW), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_clr(tok_clr),
  .bus_oe(bus_oe), .data_valid(data_valid), .bus_data(bus_data),
  .tok_out(tok_out), .rd_idx(rd_idx), .rd_ch(rd_ch),
  .capture_ev(capture_ev), .forward_ev(forward_ev), .burst_last(burst_last)
);

// File: tb/rs_readout_seq_tb_top.sv
module rs_readout_seq_tb_top;
  localparam int DW = 12, AW = 5, N_CH = 4, WORDS = 256;

  logic          clk = 1'b0;
  logic          rst_n, tok_in, tok_clr;
  logic [AW-1:0] ch_addr;
  logic [1:0]    rd_ch;
  logic [7:0]    rd_idx;
  logic [DW-1:0] rd_data, bus_data;
  logic          bus_oe, data_valid, tok_out;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // storage model: fixed arithmetic function of channel and index
  function automatic int exp_word(int ch, int i);
    return (ch * 733 + i * 17 + 5) % 4096;
  endfunction
  assign rd_data = DW'(exp_word(int'(rd_ch), int'(rd_idx)));

  rs_readout_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_clr(tok_clr), .ch_addr(ch_addr),
    .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_data(rd_data), .bus_data(bus_data),
    .bus_oe(bus_oe), .data_valid(data_valid), .tok_out(tok_out)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // token into address a; optional token pulse and address change mid-burst
  task automatic run_token(int a, int tok_at, int addr_at);
    int oe_err = 0, dat_err = 0, ch_err = 0, act = 0, expv = 0;
    ch_addr = AW'(a); tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
    if (a >= N_CH) begin
      chk(tok_out == 1'b1, "R5", "forward tok_out", int'(tok_out), 1);
      chk(bus_oe == 1'b0, "R5", "forward bus_oe", int'(bus_oe), 0);
      @(negedge clk);
      chk(tok_out == 1'b0 && bus_oe == 1'b0, "R5", "forward one cycle", int'(tok_out), 0);
      return;
    end
    for (int i = 0; i < WORDS; i++) begin
      if (!(bus_oe && data_valid) || tok_out) oe_err++;
      if (int'(rd_ch) != a) ch_err++;
      if (int'(rd_idx) != i || int'(bus_data) != exp_word(a, i)) begin
        if (dat_err == 0) begin act = int'(bus_data); expv = exp_word(a, i); end
        dat_err++;
      end
      tok_in = (i == tok_at);
      if (i == addr_at) ch_addr = AW'((a + 1) % N_CH);
      @(negedge clk);
    end
    tok_in = 1'b0;
    chk(oe_err == 0, "R2", "burst enable length", oe_err, 0);
    chk(dat_err == 0, "R3", "burst word", act, expv);
    if (addr_at >= 0) chk(ch_err == 0, "R9", "latched channel", ch_err, 0);
    chk(tok_out == 1'b1 && bus_oe == 1'b0, "R4", "token after last word", int'(tok_out), 1);
    chk(bus_data == '0, "R6", "released bus data", int'(bus_data), 0);
    ch_addr = AW'(a);
    @(negedge clk);
    chk(tok_out == 1'b0, "R4", "token one cycle", int'(tok_out), 0);
    chk(bus_oe == 1'b0, "R2", "no enable after burst", int'(bus_oe), 0);
    if (tok_at >= 0) begin
      repeat (3) @(negedge clk);
      chk(bus_oe == 1'b0 && tok_out == 1'b0, "R8", "mid-burst token ignored", int'(bus_oe), 0);
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int errs;
    rst_n = 1'b0; tok_in = 1'b0; tok_clr = 1'b0; ch_addr = '0;
    repeat (3) @(negedge clk);
    chk(!bus_oe && !data_valid && !tok_out && bus_data == '0, "R1", "reset outputs",
        int'(bus_oe) + int'(tok_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: sweep every address
    for (int a = 0; a < (1 << AW); a++) run_token(a, -1, -1);

    // R8 R9: token pulse and address change mid-burst
    run_token(1, 50, 100);
    run_token(3, 254, 0);

    // R7: clear in the middle of a burst
    ch_addr = 5'd2; tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
    repeat (20) @(negedge clk);
    tok_clr = 1'b1;
    @(negedge clk); tok_clr = 1'b0;
    chk(bus_oe == 1'b0 && tok_out == 1'b0, "R7", "clear stops burst", int'(bus_oe), 0);
    errs = 0;
    for (int i = 0; i < 300; i++) begin
      if (bus_oe || tok_out) errs++;
      @(negedge clk);
    end
    chk(errs == 0, "R7", "no token after clear", errs, 0);

    // R7: clear wins over a simultaneous local and non-local token
    ch_addr = 5'd3; tok_in = 1'b1; tok_clr = 1'b1;
    @(negedge clk); tok_in = 1'b0; tok_clr = 1'b0;
    chk(bus_oe == 1'b0 && tok_out == 1'b0, "R7", "clear beats local token", int'(bus_oe), 0);
    ch_addr = 5'd9; tok_in = 1'b1; tok_clr = 1'b1;
    @(negedge clk); tok_in = 1'b0; tok_clr = 1'b0;
    chk(tok_out == 1'b0, "R7", "clear beats forward", int'(tok_out), 0);

    // R7: chain usable after clear
    run_token(2, -1, -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule